// File: doc/BRIEF.md
# Processor Hotplug Presence and System Interrupt Controller

This block tracks which processors of a machine are present and tells the operating system when that set changes. It holds one presence bit per processor slot, packed eight to a byte, and software reads the bitmap one byte at a time through a small I/O window. When the platform adds or removes a processor, it drives a request on the hotplug port. The block updates that processor's bit and latches a shared hotplug flag in the general-purpose event status byte.

The system control interrupt is a level signal. It combines that hotplug flag, gated by its enable, with four fixed power-management event sources, each taken from the status and enable vectors supplied by the surrounding power-management logic. Software acknowledges the hotplug flag by writing a one to it. At reset the bitmap is loaded from a present-mask input, so processors that exist at power-on are already visible.

Top module: `cpu_hp_sci`

## Requirements
- R1: The presence bitmap has NUM_CPUS/8 bytes (32 by default) decoded at addresses WIN_BASE (0xAF00) to WIN_BASE+31. A one-cycle read strobe at WIN_BASE+k puts bitmap byte k on bus_rdata after the next clock edge, and the value holds until the next read. A read of an unmapped address returns 0x00.
- R2: For processor id N, the presence bit is byte N/8, bit N%8. An accepted request with hp_plug=1 sets that bit, and one with hp_plug=0 clears it. No other bit changes.
- R3: While rst is high, each bitmap byte k is loaded from present_mask[8k+7:8k]. The GPE status byte, sci, hp_err and bus_rdata are all cleared.
- R4: Every accepted plug or unplug request sets bit 2 (mask 0x04) of the GPE status byte. This byte appears on gpe0_sts and is readable at address GPE_ADDR (0xAF20).
- R5: Bus writes into the bitmap window are accepted and change no bitmap byte.
- R6: A bus write to GPE_ADDR clears each GPE status bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R7: If an accepted hotplug request arrives in the same cycle as a write that clears bit 2, bit 2 stays set.
- R8: sci is 1 when (pm1_sts & pm1_en) has any of bits 0 (timer), 5 (global lock), 8 (power button) or 10 (real-time clock) set, or when gpe0_sts bit 2 and gpe0_en bit 2 are both 1. Other PM1 bits and other GPE bits have no effect.
- R9: sci is a register. It reflects the status and enable values of the previous clock cycle, so it deasserts one cycle after bit 2 is cleared.
- R10: A request with hp_id >= NUM_CPUS is ignored: the bitmap and gpe0_sts do not change. hp_err is high for exactly the one cycle after that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| present_mask | input | NUM_CPUS | Processors present at reset |
| hp_valid | input | 1 | Hotplug request strobe |
| hp_id | input | ID_W | Processor id of the request |
| hp_plug | input | 1 | 1 = add processor, 0 = remove |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| pm1_sts | input | 16 | PM1 event status vector |
| pm1_en | input | 16 | PM1 event enable vector |
| gpe0_en | input | 8 | GPE0 enable byte |
| gpe0_sts | output | 8 | GPE0 status byte |
| sci | output | 1 | Registered system control interrupt level |
| hp_err | output | 1 | One-cycle pulse on an out-of-range id |

## Verification
The bench goes after the ids that sit on byte edges (0, 15, 63, 128, 255) and the out-of-range id 256. A design that takes the byte index from the wrong id bits would light up the wrong byte. A design that does not range-check would wrap id 256 onto processor 0 or raise the hotplug flag. The bench lands a hotplug request in the same cycle as a clear of bit 2; if the clear wins, the event is lost. The bench also times sci against a status clear, which shows whether the interrupt lags by one register. It drives PM1 bits outside the four wired sources, so an over-wide mask would raise a spurious interrupt.

// File: rtl/cpu_hp_pkg.sv
package cpu_hp_pkg;
  localparam int PM1_W = 16;
  localparam int PM1_TMR_BIT = 0;
  localparam int PM1_GLK_BIT = 5;
  localparam int PM1_PWR_BIT = 8;
  localparam int PM1_RTC_BIT = 10;
  localparam int GPE_HP_BIT  = 2;

  function automatic logic [PM1_W-1:0] pm1_src_mask();
    logic [PM1_W-1:0] m;
    m = '0;
    m[PM1_TMR_BIT] = 1'b1;
    m[PM1_GLK_BIT] = 1'b1;
    m[PM1_PWR_BIT] = 1'b1;
    m[PM1_RTC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hp_bitmap.sv
module hp_bitmap #(
  parameter int NUM_CPUS = 256,
  localparam int BYTES = NUM_CPUS / 8,
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CPUS-1:0] present_mask,
  input  logic                upd_en,
  input  logic [IDX_W-1:0]    upd_byte,
  input  logic [2:0]          upd_bit,
  input  logic                upd_val,
  input  logic [IDX_W-1:0]    rd_byte,
  output logic [7:0]          rd_data
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= present_mask[i*8 +: 8];
    end else if (upd_en) begin
      mem[upd_byte][upd_bit] <= upd_val;
    end
  end

  assign rd_data = mem[rd_byte];
endmodule

// File: rtl/hp_gpe_status.sv
module hp_gpe_status
  import cpu_hp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hp_valid,
  input  logic       hp_ok,
  input  logic       clr_wr,
  input  logic [7:0] clr_data,
  output logic [7:0] sts,
  output logic       err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      err <= 1'b0;
    end else begin
      err <= hp_valid && !hp_ok;
      if (hp_ok) begin
        sts <= (clr_wr ? (sts & ~clr_data) : sts) | (8'h1 << GPE_HP_BIT);
      end else if (clr_wr) begin
        sts <= sts & ~clr_data;
      end
    end
  end

  // R4 / R7: accepted event always leaves the hotplug flag set
  p_hp_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
    hp_ok |=> sts[GPE_HP_BIT]);

  // R6: clear without concurrent event drops the flag
  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_data[GPE_HP_BIT] && !hp_ok) |=> !sts[GPE_HP_BIT]);

  // R10: rejected id pulses the error flag
  p_bad_id_err_r10: assert property (@(posedge clk) disable iff (rst)
    (hp_valid && !hp_ok) |=> err);
endmodule

// File: rtl/hp_sci_combine.sv
module hp_sci_combine
  import cpu_hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PM1_W-1:0] pm1_sts,
  input  logic [PM1_W-1:0] pm1_en,
  input  logic [7:0]       gpe_sts,
  input  logic [7:0]       gpe_en,
  output logic             sci
);
  logic pm1_hit, gpe_hit;

  always_comb begin
    pm1_hit = |(pm1_sts & pm1_en & pm1_src_mask());
    gpe_hit = gpe_sts[GPE_HP_BIT] & gpe_en[GPE_HP_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) sci <= 1'b0;
    else     sci <= pm1_hit | gpe_hit;
  end
endmodule

// File: rtl/cpu_hp_sci.sv
module cpu_hp_sci
  import cpu_hp_pkg::*;
#(
  parameter int NUM_CPUS = 256,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hAF00,
  parameter logic [ADDR_W-1:0] GPE_ADDR = 16'hAF20,
  localparam int ID_W = $clog2(NUM_CPUS) + 1,
  localparam int BYTES = NUM_CPUS / 8,
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CPUS-1:0] present_mask,
  input  logic                hp_valid,
  input  logic [ID_W-1:0]     hp_id,
  input  logic                hp_plug,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_rd,
  input  logic                bus_wr,
  output logic [7:0]          bus_rdata,
  input  logic [15:0]         pm1_sts,
  input  logic [15:0]         pm1_en,
  input  logic [7:0]          gpe0_en,
  output logic [7:0]          gpe0_sts,
  output logic                sci,
  output logic                hp_err
);
  logic              hp_ok;
  logic [ADDR_W-1:0] offset;
  logic              in_win, gpe_hit;
  logic [7:0]        bm_byte;
  logic [IDX_W-1:0]  hp_byte, rd_byte;

  always_comb begin
    hp_ok   = hp_valid && (hp_id < ID_W'(NUM_CPUS));
    hp_byte = IDX_W'(hp_id >> 3);
    offset  = bus_addr - WIN_BASE;
    in_win  = offset < ADDR_W'(BYTES);
    rd_byte = IDX_W'(offset);
    gpe_hit = bus_addr == GPE_ADDR;
  end

  hp_bitmap #(.NUM_CPUS(NUM_CPUS)) u_bitmap (
    .clk(clk), .rst(rst), .present_mask(present_mask),
    .upd_en(hp_ok), .upd_byte(hp_byte), .upd_bit(hp_id[2:0]),
    .upd_val(hp_plug), .rd_byte(rd_byte), .rd_data(bm_byte)
  );

  hp_gpe_status u_gpe (
    .clk(clk), .rst(rst), .hp_valid(hp_valid), .hp_ok(hp_ok),
    .clr_wr(bus_wr && gpe_hit), .clr_data(bus_wdata),
    .sts(gpe0_sts), .err(hp_err)
  );

  hp_sci_combine u_sci (
    .clk(clk), .rst(rst), .pm1_sts(pm1_sts), .pm1_en(pm1_en),
    .gpe_sts(gpe0_sts), .gpe_en(gpe0_en), .sci(sci)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= in_win  ? bm_byte :
                                  gpe_hit ? gpe0_sts : 8'h00;
  end

  // R8: enabled hotplug flag drives the interrupt on the next edge
  p_sci_follows_gpe_r8: assert property (@(posedge clk) disable iff (rst)
    (gpe0_sts[GPE_HP_BIT] && gpe0_en[GPE_HP_BIT]) |=> sci);

  // R9: with no enabled source this cycle, sci is low next cycle
  p_sci_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!(gpe0_sts[GPE_HP_BIT] && gpe0_en[GPE_HP_BIT]) &&
     ((pm1_sts & pm1_en & pm1_src_mask()) == '0)) |=> !sci);

  // R10: a rejected request leaves the status byte alone
  p_bad_id_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (hp_valid && !hp_ok && !bus_wr) |=> $stable(gpe0_sts));
endmodule

// File: tb/cpu_hp_sci_test.sv
module cpu_hp_sci_test;
  localparam int N = 256;
  logic clk = 0, rst = 1;
  logic [N-1:0] present_mask;
  logic hp_valid = 0, hp_plug = 0;
  logic [8:0] hp_id = '0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_rdata, gpe0_sts;
  logic [15:0] pm1_sts = '0, pm1_en = '0;
  logic [7:0] gpe0_en = '0;
  logic sci, hp_err;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  cpu_hp_sci uut (
    .clk(clk), .rst(rst), .present_mask(present_mask),
    .hp_valid(hp_valid), .hp_id(hp_id), .hp_plug(hp_plug),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pm1_sts(pm1_sts),
    .pm1_en(pm1_en), .gpe0_en(gpe0_en), .gpe0_sts(gpe0_sts),
    .sci(sci), .hp_err(hp_err)
  );

  // {id[8:0], plug, expected byte[7:0]}; start: byte0=03, byte1=02
  localparam logic [17:0] VEC [8] = '{
    {9'd2,   1'b1, 8'h07}, {9'd0,   1'b0, 8'h06},
    {9'd15,  1'b1, 8'h82}, {9'd9,   1'b0, 8'h80},
    {9'd255, 1'b1, 8'h80}, {9'd128, 1'b1, 8'h01},
    {9'd255, 1'b0, 8'h00}, {9'd63,  1'b1, 8'h80}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hp_event(input logic [8:0] id, input logic plug);
    @(negedge clk); hp_valid = 1; hp_id = id; hp_plug = plug;
    @(negedge clk); hp_valid = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] srcs [4];
    srcs[0] = 16'h0001; srcs[1] = 16'h0020; srcs[2] = 16'h0100; srcs[3] = 16'h0400;
    present_mask = '0;
    present_mask[0] = 1; present_mask[1] = 1; present_mask[9] = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // R3 reset state
    chk(sci == 0, "R3 sci", sci, 0);
    chk(gpe0_sts == 0, "R3 gpe", gpe0_sts, 0);
    chk(hp_err == 0, "R3 err", hp_err, 0);
    rd(16'hAF00, d); chk(d == 8'h03, "R3 byte0", d, 8'h03);
    rd(16'hAF01, d); chk(d == 8'h02, "R3 byte1", d, 8'h02);
    rd(16'hAF02, d); chk(d == 8'h00, "R1 byte2", d, 0);
    rd(16'h1234, d); chk(d == 8'h00, "R1 unmapped", d, 0);

    // R2 vector table
    for (int i = 0; i < 8; i++) begin
      hp_event(VEC[i][17:9], VEC[i][8]);
      rd(16'hAF00 + 16'(VEC[i][17:12]), d);
      chk(d == VEC[i][7:0], "R2 bitmap", d, VEC[i][7:0]);
    end

    // R4 flag set, R8 gated by enable
    chk(gpe0_sts == 8'h04, "R4 gpe out", gpe0_sts, 4);
    rd(16'hAF20, d); chk(d == 8'h04, "R4 gpe read", d, 4);
    chk(sci == 0, "R8 disabled", sci, 0);
    @(negedge clk); gpe0_en = 8'h04;
    @(negedge clk); chk(sci == 1, "R8 gpe sci", sci, 1);

    // R6 clear, R9 one-cycle lag
    wr(16'hAF20, 8'h04);
    chk(gpe0_sts == 0, "R6 cleared", gpe0_sts, 0);
    chk(sci == 1, "R9 lag", sci, 1);
    @(negedge clk); chk(sci == 0, "R9 deassert", sci, 0);

    // R5 writes into bitmap ignored
    wr(16'hAF00, 8'hFF);
    rd(16'hAF00, d); chk(d == 8'h06, "R5 ignored", d, 6);

    // R10 out-of-range id
    @(negedge clk); hp_valid = 1; hp_id = 9'd256; hp_plug = 0;
    @(negedge clk); hp_valid = 0;
    chk(hp_err == 1, "R10 err pulse", hp_err, 1);
    chk(gpe0_sts == 0, "R10 gpe", gpe0_sts, 0);
    @(negedge clk); chk(hp_err == 0, "R10 err width", hp_err, 0);
    rd(16'hAF00, d); chk(d == 8'h06, "R10 byte0", d, 6);

    // R7 same-cycle event and clear
    hp_event(9'd3, 1);
    @(negedge clk); bus_wr = 1; bus_addr = 16'hAF20; bus_wdata = 8'h04;
    hp_valid = 1; hp_id = 9'd4; hp_plug = 1;
    @(negedge clk); bus_wr = 0; hp_valid = 0;
    chk(gpe0_sts[2] == 1, "R7 priority", gpe0_sts, 4);
    rd(16'hAF00, d); chk(d == 8'h1E, "R2 byte0 ids 3,4", d, 8'h1E);

    // R8 PM1 sources
    wr(16'hAF20, 8'h04); gpe0_en = 0;
    @(negedge clk); @(negedge clk);
    chk(sci == 0, "R8 idle", sci, 0);
    for (int k = 0; k < 4; k++) begin
      pm1_sts = srcs[k]; pm1_en = srcs[k];
      @(negedge clk); chk(sci == 1, "R8 pm1 source", sci, 1);
      pm1_en = 0;
      @(negedge clk); chk(sci == 0, "R8 pm1 disabled", sci, 0);
    end
    pm1_sts = 16'hFADE; pm1_en = 16'hFADE & ~16'h0521;
    @(negedge clk); @(negedge clk);
    chk(sci == 0, "R8 other bits", sci, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule